// File: doc/BRIEF.md
# Bus switching activity monitor

This block watches the output pins of a processor's external bus and measures how much switching they do, as a stand-in for AC power. Each valid sample holds four groups of pins: a 30-bit instruction word address, a 30-bit data word address, 32 data bits and 4 byte strobes, 96 pins in all. For every group the block counts the bits that differ from the last value that group held on the pins. The counts are added up over a window of valid samples whose length is an input. When a window closes, the block latches the group counts, their total and an energy figure, and pulses a done flag.

Switching power grows with load capacitance, the square of the voltage swing, the clock rate and the number of pins that change per clock. Capacitance, voltage and the one-half factor are folded into one integer coefficient, so the energy figure is the window's transition total times that coefficient. Its width is set by a parameter, and it clamps at all ones instead of wrapping. On a load the data pins are driven by memory, not by the processor. Load cycles therefore add nothing to the data count, and the next store is compared with the last value the processor drove.

Top module: `swmon_top`

## Requirements
- R1: While rst_n is low at a rising edge, all latched outputs become zero and win_done becomes 0.
- R2: For an accepted sample, a group's toggle count is the number of bits that differ between its present input and the last value captured for that group. The groups are iaddr (30 bits), daddr (30 bits), data (32 bits) and strobe (4 bits).
- R3: The first sample a group captures after reset only loads that group's previous value and adds zero toggles.
- R4: A cycle with smp_valid low is ignored. It captures nothing, adds no toggles and does not advance the window.
- R5: A valid sample with smp_is_load=1 adds zero data toggles and leaves the data group's previous value unchanged. The other three groups are counted normally.
- R6: A window closes on the valid sample that makes the number of valid samples in the window reach win_len, with win_len=0 treated as 1. If win_len is lowered below the number already taken, the window closes on the next valid sample. win_done is high for exactly the cycle after that edge. The latched counts include the closing sample, and the next window starts from zero.
- R7: win_total equals the sum of the four latched group counts.
- R8: win_energy equals win_total times COEF, clamped to 2^EN_W-1 when the product does not fit.
- R9: The latched outputs do not change between window closures.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Bus sample is present this cycle |
| smp_is_load | input | 1 | Data phase is a load, so the data pins are driven externally |
| iaddr | input | 30 | Instruction word address pins |
| daddr | input | 30 | Data word address pins |
| data | input | 32 | Data pins |
| strobe | input | 4 | Byte strobe pins |
| win_len | input | WIN_W (16) | Valid samples per window |
| win_done | output | 1 | One-cycle pulse: a window has closed |
| win_ia_cnt | output | CNT_W (23) | Latched instruction address toggles |
| win_da_cnt | output | CNT_W (23) | Latched data address toggles |
| win_dt_cnt | output | CNT_W (23) | Latched data toggles |
| win_bs_cnt | output | CNT_W (23) | Latched byte strobe toggles |
| win_total | output | CNT_W (23) | Latched sum of all group toggles |
| win_energy | output | EN_W (20) | Latched, clamped energy estimate |

## Verification
A window's closing sample is also a sample that is being counted. Its toggles must reach the latched results, and the accumulators must clear in that same edge. With win_len at 1, every valid sample closes a window, and a worst-case pattern (instruction address alternating all-zeros and all-ones, the other groups alternating 0x55/0xAA patterns) then gives 96 toggles in a single closing cycle. Load samples and idle cycles are placed on closing edges and just before them, and win_len is lowered in the middle of a window. Each latched value is compared with an arithmetic model of the pin history after every edge, and the model also expects the outputs to hold between closures.

// File: rtl/swmon_pkg.sv
// Package swmon_pkg: bus group geometry shared by the monitor.
// Assumes groups are packed LSB-first in the order ia, da, dt, bs.
package swmon_pkg;
    localparam int NGRP  = 4;
    localparam int G_IA  = 0;
    localparam int G_DA  = 1;
    localparam int G_DT  = 2;
    localparam int G_BS  = 3;
    localparam int BUS_W = 96;
    localparam int TOG_W = $clog2(BUS_W + 1);

    // Width in pins of group g.
    function automatic int grp_width(input int g);
        case (g)
            G_IA:    return 30;
            G_DA:    return 30;
            G_DT:    return 32;
            default: return 4;
        endcase
    endfunction

    // Bit offset of group g inside the packed bus.
    function automatic int grp_off(input int g);
        int o;
        o = 0;
        for (int i = 0; i < g; i++) o += grp_width(i);
        return o;
    endfunction
endpackage

// File: rtl/swmon_group.sv
// Module swmon_group: per-group transition counter.
// Holds the last captured pin value of one group and reports the popcount
// of the difference for a sample it takes. Assumes take is low whenever the
// processor is not the driver of these pins.
module swmon_group #(
    parameter int W     = 30,
    parameter int TOG_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic [W-1:0]     cur,
    output logic [TOG_W-1:0] toggles
);
    logic [W-1:0] prev;
    logic         primed;
    logic [W-1:0] diff;

    // Capture the driven value and mark the group primed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev   <= '0;
            primed <= 1'b0;
        end else if (take) begin
            prev   <= cur;
            primed <= 1'b1;
        end
    end

    // Count differing pins; zero when not taken or not yet primed.
    always_comb begin
        diff    = cur ^ prev;
        toggles = '0;
        if (take && primed) begin
            for (int i = 0; i < W; i++) toggles = toggles + TOG_W'(diff[i]);
        end
    end
endmodule

// File: rtl/swmon_window.sv
// Module swmon_window: counts valid samples and flags the closing one.
// A length of zero acts as one; a length below the count already taken
// closes the window on the next valid sample.
module swmon_window #(
    parameter int WIN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid,
    input  logic [WIN_W-1:0] win_len,
    output logic             close
);
    logic [WIN_W-1:0] cnt;
    logic [WIN_W:0]   eff_len;
    logic [WIN_W:0]   next_cnt;

    // Decide whether this valid sample completes the window.
    always_comb begin
        eff_len  = (win_len == '0) ? (WIN_W+1)'(1) : {1'b0, win_len};
        next_cnt = {1'b0, cnt} + (WIN_W+1)'(1);
        close    = valid && (next_cnt >= eff_len);
    end

    // Advance or restart the sample counter.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (close)  cnt <= '0;
        else if (valid)  cnt <= next_cnt[WIN_W-1:0];
    end
endmodule

// File: rtl/swmon_accum.sv
// Module swmon_accum: accumulator and result latch for one group.
// Assumes toggles is zero on cycles without a valid sample.
module swmon_accum #(
    parameter int TOG_W = 7,
    parameter int CNT_W = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid,
    input  logic             close,
    input  logic [TOG_W-1:0] toggles,
    output logic [CNT_W-1:0] win_sum,
    output logic [CNT_W-1:0] latched
);
    logic [CNT_W-1:0] acc;

    // Running window sum including the present sample.
    always_comb win_sum = acc + CNT_W'(toggles);

    // Accumulate, restarting from zero when the window closes.
    always_ff @(posedge clk) begin
        if (!rst_n)      acc <= '0;
        else if (close)  acc <= '0;
        else if (valid)  acc <= win_sum;
    end

    // Latch the finished window result.
    always_ff @(posedge clk) begin
        if (!rst_n)      latched <= '0;
        else if (close)  latched <= win_sum;
    end
endmodule

// File: rtl/swmon_energy.sv
// Module swmon_energy: transitions times coefficient, clamped to EN_W bits.
// Purely combinational; the coefficient stands for 0.5*C*V^2 in fixed point.
module swmon_energy #(
    parameter int CNT_W  = 23,
    parameter int COEF   = 3,
    parameter int COEF_W = 8,
    parameter int EN_W   = 20
) (
    input  logic [CNT_W-1:0] total,
    output logic [EN_W-1:0]  energy
);
    localparam int PW = CNT_W + COEF_W;
    localparam logic [PW-1:0] K = PW'(COEF);

    logic [PW-1:0] prod;

    // Full-width product.
    always_comb prod = PW'(total) * K;

    generate
        if (EN_W >= PW) begin : g_wide
            // Product always fits.
            always_comb energy = EN_W'(prod);
        end else begin : g_clamp
            localparam logic [PW-1:0] CAP = PW'({EN_W{1'b1}});
            // Clamp at all ones.
            always_comb energy = (prod > CAP) ? {EN_W{1'b1}} : prod[EN_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/swmon_top.sv
// Module swmon_top: bus switching activity monitor.
// Counts output-pin transitions per group over windows of valid samples and
// latches counts, total and a clamped energy estimate. Data pins on a load
// are not driven by the processor and are excluded.
module swmon_top #(
    parameter int WIN_W  = 16,
    parameter int COEF   = 3,
    parameter int COEF_W = 8,
    parameter int EN_W   = 20
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     smp_valid,
    input  logic                                     smp_is_load,
    input  logic [29:0]                              iaddr,
    input  logic [29:0]                              daddr,
    input  logic [31:0]                              data,
    input  logic [3:0]                               strobe,
    input  logic [WIN_W-1:0]                         win_len,
    output logic                                     win_done,
    output logic [WIN_W+swmon_pkg::TOG_W-1:0]        win_ia_cnt,
    output logic [WIN_W+swmon_pkg::TOG_W-1:0]        win_da_cnt,
    output logic [WIN_W+swmon_pkg::TOG_W-1:0]        win_dt_cnt,
    output logic [WIN_W+swmon_pkg::TOG_W-1:0]        win_bs_cnt,
    output logic [WIN_W+swmon_pkg::TOG_W-1:0]        win_total,
    output logic [EN_W-1:0]                          win_energy
);
    import swmon_pkg::*;

    localparam int CNT_W = WIN_W + TOG_W;

    logic [BUS_W-1:0] bus;
    logic             close;
    logic [NGRP-1:0]  take;
    logic [TOG_W-1:0] tog     [NGRP];
    logic [CNT_W-1:0] sum_g   [NGRP];
    logic [CNT_W-1:0] lat_g   [NGRP];
    logic [CNT_W-1:0] sum_all;
    logic [EN_W-1:0]  en_next;

    // Pack the pin groups LSB-first.
    always_comb bus = {strobe, data, daddr, iaddr};

    swmon_window #(.WIN_W(WIN_W)) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid   (smp_valid),
        .win_len (win_len),
        .close   (close)
    );

    generate
        for (genvar g = 0; g < NGRP; g++) begin : g_grp
            localparam int GW = grp_width(g);
            localparam int GO = grp_off(g);

            // A group is taken when sampled and driven by the processor.
            if (g == G_DT) begin : g_drv_dt
                always_comb take[g] = smp_valid && !smp_is_load;
            end else begin : g_drv
                always_comb take[g] = smp_valid;
            end

            swmon_group #(.W(GW), .TOG_W(TOG_W)) u_grp (
                .clk     (clk),
                .rst_n   (rst_n),
                .take    (take[g]),
                .cur     (bus[GO +: GW]),
                .toggles (tog[g])
            );

            swmon_accum #(.TOG_W(TOG_W), .CNT_W(CNT_W)) u_acc (
                .clk     (clk),
                .rst_n   (rst_n),
                .valid   (smp_valid),
                .close   (close),
                .toggles (tog[g]),
                .win_sum (sum_g[g]),
                .latched (lat_g[g])
            );
        end
    endgenerate

    // Sum of the finishing window over all groups.
    always_comb begin
        sum_all = '0;
        for (int g = 0; g < NGRP; g++) sum_all = sum_all + sum_g[g];
    end

    swmon_energy #(.CNT_W(CNT_W), .COEF(COEF), .COEF_W(COEF_W), .EN_W(EN_W)) u_en (
        .total  (sum_all),
        .energy (en_next)
    );

    // Latch total, energy and the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_total  <= '0;
            win_energy <= '0;
            win_done   <= 1'b0;
        end else begin
            win_done <= close;
            if (close) begin
                win_total  <= sum_all;
                win_energy <= en_next;
            end
        end
    end

    // Expose group results.
    always_comb begin
        win_ia_cnt = lat_g[G_IA];
        win_da_cnt = lat_g[G_DA];
        win_dt_cnt = lat_g[G_DT];
        win_bs_cnt = lat_g[G_BS];
    end
endmodule

// File: rtl/swmon_chk.sv
// Module swmon_chk: temporal properties of the monitor outputs.
module swmon_chk #(
    parameter int CNT_W = 23,
    parameter int EN_W  = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             smp_valid,
    input logic             win_done,
    input logic [CNT_W-1:0] win_ia_cnt,
    input logic [CNT_W-1:0] win_da_cnt,
    input logic [CNT_W-1:0] win_dt_cnt,
    input logic [CNT_W-1:0] win_bs_cnt,
    input logic [CNT_W-1:0] win_total,
    input logic [EN_W-1:0]  win_energy
);
    // R6: a closure needs an accepted sample on the edge before.
    a_r6_done_after_valid: assert property (@(posedge clk) disable iff (!rst_n)
        win_done |-> $past(smp_valid));

    // R9: results hold outside closures.
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !win_done |-> ($stable(win_total) && $stable(win_energy) && $stable(win_dt_cnt)));

    // R7: total matches the group results.
    a_r7_total_sum: assert property (@(posedge clk) disable iff (!rst_n)
        (CNT_W+2)'(win_total) == (CNT_W+2)'(win_ia_cnt) + (CNT_W+2)'(win_da_cnt)
                               + (CNT_W+2)'(win_dt_cnt) + (CNT_W+2)'(win_bs_cnt));

    // R8: no transitions means no energy.
    a_r8_zero_energy: assert property (@(posedge clk) disable iff (!rst_n)
        (win_total == '0) |-> (win_energy == '0));
endmodule

bind swmon_top swmon_chk #(.CNT_W(CNT_W), .EN_W(EN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_valid  (smp_valid),
    .win_done   (win_done),
    .win_ia_cnt (win_ia_cnt),
    .win_da_cnt (win_da_cnt),
    .win_dt_cnt (win_dt_cnt),
    .win_bs_cnt (win_bs_cnt),
    .win_total  (win_total),
    .win_energy (win_energy)
);

// File: tb/tb_swmon_top.sv
// Bench for swmon_top: arithmetic model of pin history, checked every edge.
module tb_swmon_top;
    localparam int  CNT_W = 23;
    localparam int  EN_W  = 20;
    localparam longint EMAX = (64'd1 << EN_W) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic        smp_is_load = 1'b0;
    logic [29:0] iaddr = '0;
    logic [29:0] daddr = '0;
    logic [31:0] data = '0;
    logic [3:0]  strobe = '0;
    logic [15:0] win_len = 16'd1;
    logic        win_done;
    logic [CNT_W-1:0] win_ia_cnt, win_da_cnt, win_dt_cnt, win_bs_cnt, win_total;
    logic [EN_W-1:0]  win_energy;

    always #10 clk = ~clk;

    swmon_top dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_is_load(smp_is_load),
        .iaddr(iaddr), .daddr(daddr), .data(data), .strobe(strobe), .win_len(win_len),
        .win_done(win_done), .win_ia_cnt(win_ia_cnt), .win_da_cnt(win_da_cnt),
        .win_dt_cnt(win_dt_cnt), .win_bs_cnt(win_bs_cnt), .win_total(win_total),
        .win_energy(win_energy)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // model state
    logic [29:0] p_ia, p_da;
    logic [31:0] p_dt;
    logic [3:0]  p_bs;
    bit pr_ia, pr_da, pr_dt, pr_bs;
    longint acc [4];
    longint lat [4];
    longint lat_tot, lat_en;
    int cnt;
    logic [31:0] rng = 32'h1234_5678;

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_clear();
        pr_ia = 0; pr_da = 0; pr_dt = 0; pr_bs = 0;
        p_ia = '0; p_da = '0; p_dt = '0; p_bs = '0;
        for (int g = 0; g < 4; g++) begin acc[g] = 0; lat[g] = 0; end
        lat_tot = 0; lat_en = 0; cnt = 0;
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] s);
        logic [31:0] x;
        x = s ^ (s << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
        return x;
    endfunction

    // R1: reset clears results.
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; smp_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_clear();
        chk("R1 done low", win_done, 0);
        chk("R1 total zero", win_total, 0);
        chk("R1 energy zero", win_energy, 0);
        chk("R1 data count zero", win_dt_cnt, 0);
    endtask

    task automatic step(input bit v, input bit ld, input logic [29:0] ia,
                        input logic [29:0] da, input logic [31:0] dt, input logic [3:0] bs);
        longint t [4];
        longint eff, e;
        bit done;
        @(negedge clk);
        smp_valid = v; smp_is_load = ld; iaddr = ia; daddr = da; data = dt; strobe = bs;
        @(posedge clk);
        #1;
        done = 0;
        if (v) begin
            // R2/R3: popcount against last captured value, zero when unprimed.
            t[0] = pr_ia ? $countones(ia ^ p_ia) : 0;
            t[1] = pr_da ? $countones(da ^ p_da) : 0;
            t[3] = pr_bs ? $countones(bs ^ p_bs) : 0;
            // R5: loads contribute nothing and keep the old data value.
            t[2] = (!ld && pr_dt) ? $countones(dt ^ p_dt) : 0;
            p_ia = ia; pr_ia = 1; p_da = da; pr_da = 1; p_bs = bs; pr_bs = 1;
            if (!ld) begin p_dt = dt; pr_dt = 1; end
            for (int g = 0; g < 4; g++) acc[g] += t[g];
            cnt++;
            eff = (win_len == 0) ? 1 : win_len;
            if (cnt >= eff) begin
                done = 1;
                lat_tot = 0;
                for (int g = 0; g < 4; g++) begin
                    lat[g] = acc[g]; lat_tot += acc[g]; acc[g] = 0;
                end
                e = lat_tot * 3;
                lat_en = (e > EMAX) ? EMAX : e;
                cnt = 0;
            end
        end
        // R4: idle cycles leave model untouched; outputs must agree.
        chk("R6 done pulse", win_done, done);
        chk("R2 iaddr count", win_ia_cnt, lat[0]);
        chk("R2 daddr count", win_da_cnt, lat[1]);
        chk("R5 data count", win_dt_cnt, lat[2]);
        chk("R2 strobe count", win_bs_cnt, lat[3]);
        chk("R7 total", win_total, lat_tot);
        chk("R8 energy", win_energy, lat_en);
    endtask

    // Worst-case alternating pattern, phase k.
    task automatic worst(input int k, input bit ld);
        if (k % 2 == 1) step(1, ld, 30'h3FFFFFFF, 30'h15555555, 32'hAAAAAAAA, 4'hF);
        else            step(1, ld, 30'h00000000, 30'h2AAAAAAA, 32'h55555555, 4'h0);
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        do_reset();

        // R3 and R2: first sample primes, then 96-pin swings, one window per sample.
        win_len = 16'd1;
        for (int k = 0; k < 6; k++) worst(k, 0);
        chk("R2 worst total", win_total, 96);

        // R4: idle cycles with wild values, then repeat last sample -> zero.
        step(0, 0, 30'h1234567, 30'h3ABCDEF, 32'hDEADBEEF, 4'h5);
        step(0, 1, 30'h0, 30'h3FFFFFFF, 32'h0, 4'hA);
        worst(5, 0);
        chk("R4 idle ignored", win_total, 0);

        // R5: load with different data excluded; following store compares to last store.
        worst(0, 0);
        step(1, 1, 30'h0, 30'h2AAAAAAA, 32'hFFFF0000, 4'h0);
        chk("R5 load no data toggles", win_dt_cnt, 0);
        worst(0, 0);
        chk("R5 store vs last store", win_dt_cnt, 0);

        // R6: zero length acts as one.
        win_len = 16'd0;
        worst(1, 0);
        worst(2, 1);
        chk("R6 len zero closes", win_done, 1);

        // R6: sweep window lengths with random samples, loads and gaps.
        for (int len = 2; len <= 7; len++) begin
            win_len = 16'(len);
            for (int s = 0; s < 4 * len; s++) begin
                rng = nxt(rng);
                step(rng[1:0] != 2'b00, rng[2], 30'(nxt(rng)), 30'(nxt(rng) >> 2),
                     nxt(nxt(rng)), rng[7:4]);
            end
        end

        // R6: shrinking length closes on the next valid sample.
        win_len = 16'd10;
        for (int s = 0; s < 5; s++) worst(s, 0);
        win_len = 16'd3;
        worst(5, 0);
        chk("R6 shrink closes", win_done, 1);

        // R8: long worst-case window exceeds energy range and clamps.
        win_len = 16'd4000;
        for (int s = 0; s < 4000; s++) worst(s, 0);
        chk("R8 clamp", win_energy, EMAX);

        // R3: reset in mid-run re-primes every group.
        win_len = 16'd1;
        worst(0, 0);
        do_reset();
        worst(1, 0);
        chk("R3 first after reset zero", win_total, 0);
        worst(0, 0);
        chk("R3 second after reset full", win_total, 96);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule